// File: doc/BRIEF.md
# Edge-Armed Word Boundary Aligner

This block sits behind a deserializer that delivers a 16-bit parallel word each clock with an unknown bit boundary. It looks for a fixed 16-bit alignment pattern, given as a parameter, at every one of the 16 bit offsets that span the current word and the word before it. It checks all 16 offsets in the same cycle. The search does not run all the time. A low-to-high transition on the alignment-enable input arms it. The first pattern found after that transition fixes the boundary, and from then on the block emits realigned words at that offset.

Two status vectors travel with the data through the same register stage. The first is a per-byte pattern-hit flag that marks the aligned word holding the pattern. The second is a per-byte lock flag that stays high until the next arming edge. The boundary stays fixed even when the enable input is held high. To realign, the enable input must drop and then rise again.

Top module: `wa_top`

## Requirements
- R1: A synchronous active-high reset clears the aligned word, the hit flags and the lock flags to zero and forgets the previous enable level. If `align_en` is high on the first clock edge after reset is released, that edge arms a search.
- R2: While no boundary is locked, `aligned_word` equals the `rx_word` sampled two clock edges earlier (offset 0), and both status vectors read 2'b00.
- R3: A search is armed only on a clock edge where `align_en` is 1 and was 0 on the previous edge. Patterns that arrive while the block is not armed, or while `align_en` stays high after a lock, never start a new lock. Matching starts on the edge after the arming edge.
- R4: In an armed state, the first pattern found locks the boundary. On the output cycle of that pattern the word shows the pattern, `pat_hit` reads 2'b10 and `lock_flags` rises to 2'b11.
- R5: Once locked, a pattern found at any other bit offset does not move the boundary and raises no hit flag.
- R6: `pat_hit` is 2'b10 for exactly those output cycles in which the aligned word at the locked offset equals the pattern, and 2'b00 otherwise. Bit 0 (the low byte) never rises. Each further pattern at the locked offset gives another one-cycle flag.
- R7: `lock_flags` stays 2'b11 from the lock until the output cycle after an arming edge, where it reads 2'b00. Data and both status vectors share one register stage, so they have the same latency.
- R8: The stream is taken most significant bit first. A pattern whose first bit lands at bit position p of a received word (0 = MSB) comes out on `aligned_word` exactly equal to the pattern, with that first bit in bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| align_en | input | 1 | Alignment enable; a rising edge arms a search |
| rx_word | input | 16 | Unaligned word from the deserializer, MSB received first |
| aligned_word | output | 16 | Word at the locked bit offset, or offset 0 when unlocked |
| pat_hit | output | 2 | Per-byte pattern flag; bit 1 marks the byte that starts the pattern |
| lock_flags | output | 2 | Per-byte lock status, both bits equal |

## Verification
A wrong stored offset shows up on `aligned_word` on the first output cycle after the lock. It then shows again in the missing or misplaced `pat_hit` pulse on the next repeated pattern. A stuck arming flag or a lost edge register shows up as a relock on a pattern at a new phase, or as a missing lock after the enable rises. Either appears within two cycles of the word that carries that pattern. The bench's reference model tracks the bit history on its own and compares all three outputs on every clock, so any error in the boundary or the flags is caught in the cycle it first appears.

// File: rtl/wa_pkg.sv
package wa_pkg;
   typedef enum logic [1:0] {
      WA_IDLE = 2'd0,
      WA_HUNT = 2'd1,
      WA_LOCK = 2'd2
   } wa_state_e;
endpackage

// File: rtl/wa_window.sv
// Holds the current word and the low bits of the previous one, forming a
// (2*WORD_W-1)-bit window; bit 0 is the most recently received bit.
module wa_window #(
   parameter int WORD_W = 16,
   localparam int WIN_W = 2 * WORD_W - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] din,
   output logic [WIN_W-1:0]  win
);
   logic [WORD_W-1:0] cur_q;
   logic [WORD_W-2:0] prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q  <= '0;
         prev_q <= '0;
      end else begin
         cur_q  <= din;
         prev_q <= cur_q[WORD_W-2:0];
      end
   end

   assign win = {prev_q, cur_q};
endmodule

// File: rtl/wa_match.sv
// Compares every offset of the window against the pattern in parallel and
// reports the lowest matching offset.
module wa_match #(
   parameter int WORD_W = 16,
   parameter logic [WORD_W-1:0] PATTERN = 16'hF628,
   localparam int WIN_W = 2 * WORD_W - 1,
   localparam int OFF_W = $clog2(WORD_W)
) (
   input  logic [WIN_W-1:0]  win,
   output logic [WORD_W-1:0] hit,
   output logic              any_hit,
   output logic [OFF_W-1:0]  low_off
);
   for (genvar k = 0; k < WORD_W; k++) begin : g_cmp
      assign hit[k] = (win[k +: WORD_W] == PATTERN);
   end

   assign any_hit = |hit;

   always_comb begin
      low_off = '0;
      for (int k = WORD_W - 1; k >= 0; k--) begin
         if (hit[k]) low_off = OFF_W'(k);
      end
   end
endmodule

// File: rtl/wa_slice.sv
// Picks the aligned word out of the window; the variant is chosen by MUX_STYLE.
module wa_slice #(
   parameter int WORD_W = 16,
   parameter int MUX_STYLE = 0,
   localparam int WIN_W = 2 * WORD_W - 1,
   localparam int OFF_W = $clog2(WORD_W)
) (
   input  logic [WIN_W-1:0]  win,
   input  logic [OFF_W-1:0]  off,
   output logic [WORD_W-1:0] word
);
   if (MUX_STYLE == 0) begin : g_shift
      assign word = win[off +: WORD_W];
   end else begin : g_table
      logic [WORD_W-1:0] cand [WORD_W];
      for (genvar k = 0; k < WORD_W; k++) begin : g_cand
         assign cand[k] = win[k +: WORD_W];
      end
      assign word = cand[off];
   end
endmodule

// File: rtl/wa_ctrl.sv
// Edge detection, arming and lock bookkeeping; decides the offset and the
// status for the output stage in the current cycle.
module wa_ctrl
   import wa_pkg::*;
#(
   parameter int WORD_W = 16,
   localparam int OFF_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [WORD_W-1:0] hit,
   input  logic              any_hit,
   input  logic [OFF_W-1:0]  low_off,
   output logic [OFF_W-1:0]  sel_off,
   output logic              hit_now,
   output logic              sync_now
);
   wa_state_e        state_q;
   logic             en_q;
   logic [OFF_W-1:0] off_q;
   logic             rise;
   logic             take;
   logic             held;

   assign rise = en & ~en_q;
   assign take = (state_q == WA_HUNT) & any_hit & ~rise;
   assign held = (state_q == WA_LOCK) & ~rise;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= WA_IDLE;
         en_q    <= 1'b0;
         off_q   <= '0;
      end else begin
         en_q <= en;
         if (rise) begin
            state_q <= WA_HUNT;
         end else if (take) begin
            state_q <= WA_LOCK;
            off_q   <= low_off;
         end
      end
   end

   always_comb begin
      sel_off = '0;
      if (take)      sel_off = low_off;
      else if (held) sel_off = off_q;
   end

   assign hit_now  = take | (held & hit[off_q]);
   assign sync_now = take | held;
endmodule

// File: rtl/wa_top.sv
module wa_top #(
   parameter int WORD_W = 16,
   parameter logic [WORD_W-1:0] PATTERN = 16'hF628,
   parameter int MUX_STYLE = 0,
   localparam int BYTES = WORD_W / 8,
   localparam int WIN_W = 2 * WORD_W - 1,
   localparam int OFF_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              align_en,
   input  logic [WORD_W-1:0] rx_word,
   output logic [WORD_W-1:0] aligned_word,
   output logic [BYTES-1:0]  pat_hit,
   output logic [BYTES-1:0]  lock_flags
);
   if (WORD_W < 16 || (WORD_W % 8) != 0) begin : g_bad_width
      $error("wa_top: WORD_W must be a multiple of 8 and at least 16");
   end
   if (MUX_STYLE != 0 && MUX_STYLE != 1) begin : g_bad_style
      $error("wa_top: MUX_STYLE must be 0 or 1");
   end

   logic [WIN_W-1:0]  win;
   logic [WORD_W-1:0] hit;
   logic              any_hit;
   logic [OFF_W-1:0]  low_off;
   logic [OFF_W-1:0]  sel_off;
   logic              hit_now;
   logic              sync_now;
   logic [WORD_W-1:0] word_c;

   wa_window #(.WORD_W(WORD_W)) u_win (
      .clk(clk), .rst(rst), .din(rx_word), .win(win)
   );

   wa_match #(.WORD_W(WORD_W), .PATTERN(PATTERN)) u_match (
      .win(win), .hit(hit), .any_hit(any_hit), .low_off(low_off)
   );

   wa_ctrl #(.WORD_W(WORD_W)) u_ctrl (
      .clk(clk), .rst(rst), .en(align_en), .hit(hit), .any_hit(any_hit),
      .low_off(low_off), .sel_off(sel_off), .hit_now(hit_now),
      .sync_now(sync_now)
   );

   wa_slice #(.WORD_W(WORD_W), .MUX_STYLE(MUX_STYLE)) u_slice (
      .win(win), .off(sel_off), .word(word_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         aligned_word <= '0;
         pat_hit      <= '0;
         lock_flags   <= '0;
      end else begin
         aligned_word <= word_c;
         pat_hit      <= {hit_now, {(BYTES-1){1'b0}}};
         lock_flags   <= {BYTES{sync_now}};
      end
   end
endmodule

// File: rtl/wa_top_chk.sv
module wa_top_chk #(
   parameter int WORD_W = 16,
   localparam int BYTES = WORD_W / 8
) (
   input logic              clk,
   input logic              rst,
   input logic              align_en,
   input logic [WORD_W-1:0] rx_word,
   input logic [WORD_W-1:0] aligned_word,
   input logic [BYTES-1:0]  pat_hit,
   input logic [BYTES-1:0]  lock_flags
);
   logic [1:0] warm;

   always_ff @(posedge clk) begin
      if (rst)               warm <= 2'd0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   // R2: unlocked output is the input from two edges before
   p_pass_unlocked_r2: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2 && !lock_flags[BYTES-1]) |-> aligned_word == $past(rx_word, 2));

   // R4: a new lock always comes with the hit flag
   p_lock_det_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(lock_flags[BYTES-1]) |-> pat_hit[BYTES-1]);

   // R6: a hit is only reported while locked
   p_det_sync_r6: assert property (@(posedge clk) disable iff (rst)
      pat_hit[BYTES-1] |-> lock_flags[BYTES-1]);

   // R7: an arming edge clears the lock flag on the next output
   p_rise_clears_r7: assert property (@(posedge clk) disable iff (rst)
      (align_en && !$past(align_en)) |=> !lock_flags[BYTES-1]);

   // R7: the lock flag holds until an arming edge
   p_sync_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (lock_flags[BYTES-1] && !(align_en && !$past(align_en))) |=> lock_flags[BYTES-1]);
endmodule

bind wa_top wa_top_chk #(.WORD_W(WORD_W)) chk_i (
   .clk(clk), .rst(rst), .align_en(align_en), .rx_word(rx_word),
   .aligned_word(aligned_word), .pat_hit(pat_hit), .lock_flags(lock_flags)
);

// File: tb/wa_top_tb_top.sv
module wa_top_tb_top;
   localparam logic [15:0] PAT = 16'hF628;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst = 1'b1;
   logic        align_en = 1'b0;
   logic [15:0] rx_word = '0;
   logic [15:0] aligned_word;
   logic [1:0]  pat_hit;
   logic [1:0]  lock_flags;

   wa_top dut_i (
      .clk(clk), .rst(rst), .align_en(align_en), .rx_word(rx_word),
      .aligned_word(aligned_word), .pat_hit(pat_hit), .lock_flags(lock_flags)
   );

   int total = 0;
   int bad = 0;
   int dets = 0;
   bit armed = 0;

   // bit stream source
   bit     bq[$];
   longint bits_total = 0;
   int     ones_run = 0;

   // reference model state
   logic [15:0] h1, h2;
   bit          en_prev, hunting, locked;
   int          off;
   logic [15:0] e_dout;
   logic [1:0]  e_det, e_sync;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic push_bit(bit b);
      bq.push_back(b);
      bits_total++;
      ones_run = b ? ones_run + 1 : 0;
   endtask

   // noise never holds four ones in a row, so it cannot form the pattern
   task automatic noise(int n);
      for (int i = 0; i < n; i++) begin
         if (ones_run >= 3) push_bit(1'b0);
         else push_bit(1'($urandom_range(0, 1)));
      end
   endtask

   task automatic put_pat();
      for (int i = 15; i >= 0; i--) push_bit(PAT[i]);
   endtask

   task automatic pad_to(int phase);
      while ((bits_total % 16) != longint'(phase)) noise(1);
   endtask

   function automatic logic [15:0] take_word();
      logic [15:0] w;
      for (int i = 15; i >= 0; i--) w[i] = bq.pop_front();
      return w;
   endfunction

   function automatic logic [15:0] slice_at(int k);
      logic [31:0] w;
      w = {h2, h1} >> k;
      return w[15:0];
   endfunction

   task automatic model_step(logic r, logic e, logic [15:0] d);
      int  first;
      bit  rise;
      if (r) begin
         h1 = '0; h2 = '0; en_prev = 0; hunting = 0; locked = 0; off = 0;
         e_dout = '0; e_det = 2'b00; e_sync = 2'b00;
         return;
      end
      rise  = e && !en_prev;
      first = -1;
      if (hunting && !rise)
         for (int k = 0; k < 16; k++)
            if (first < 0 && slice_at(k) == PAT) first = k;
      if (rise) begin
         e_dout = slice_at(0); e_det = 2'b00; e_sync = 2'b00;
         hunting = 1; locked = 0;
      end else if (first >= 0) begin
         e_dout = slice_at(first); e_det = 2'b10; e_sync = 2'b11;
         hunting = 0; locked = 1; off = first;
      end else if (locked) begin
         e_dout = slice_at(off);
         e_det  = (slice_at(off) == PAT) ? 2'b10 : 2'b00;
         e_sync = 2'b11;
      end else begin
         e_dout = slice_at(0); e_det = 2'b00; e_sync = 2'b00;
      end
      h2 = h1; h1 = d; en_prev = e;
   endtask

   task automatic cycle(logic r, logic e, logic [15:0] d);
      @(negedge clk);
      if (armed) begin
         chk(e_sync == 2'b00 ? "R2 unlocked dout" : "R4 aligned dout",
             32'(aligned_word), 32'(e_dout));
         chk("R6 pat_hit", 32'(pat_hit), 32'(e_det));
         chk("R7 lock_flags", 32'(lock_flags), 32'(e_sync));
         if (pat_hit[1] === 1'b1) begin
            dets++;
            chk("R8 flagged word equals pattern", 32'(aligned_word), 32'(PAT));
         end
      end
      rst = r; align_en = e; rx_word = d;
      model_step(r, e, d);
      armed = 1;
   endtask

   task automatic run(logic e, int extra);
      while (bq.size() > 0) begin
         if (bq.size() < 16) noise(16 - bq.size());
         cycle(1'b0, e, take_word());
      end
      for (int i = 0; i < extra; i++) begin
         noise(16);
         cycle(1'b0, e, take_word());
      end
   endtask

   initial begin
      int d0;
      // R1: reset state
      for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 16'hFFFF);
      noise(16);
      cycle(1'b0, 1'b0, take_word());
      chk("R1 reset dout", 32'(aligned_word), 32'h0);
      chk("R1 reset pat_hit", 32'(pat_hit), 32'h0);
      chk("R1 reset lock_flags", 32'(lock_flags), 32'h0);

      // R3: pattern without an arming edge is ignored
      run(1'b0, 4);
      d0 = dets;
      pad_to(3); put_pat();
      run(1'b0, 4);
      chk("R3 no lock without edge", 32'(lock_flags), 32'h0);
      chk("R3 no hit without edge", 32'(dets - d0), 32'd0);

      // R4: arm, then lock at phase 5
      run(1'b1, 2);
      d0 = dets;
      pad_to(5); put_pat();
      run(1'b1, 4);
      chk("R4 locked after first pattern", 32'(lock_flags), 32'h3);
      chk("R4 one hit on lock", 32'(dets - d0), 32'd1);

      // R5: other phase ignored
      d0 = dets;
      pad_to(9); put_pat();
      run(1'b1, 4);
      chk("R5 other phase no hit", 32'(dets - d0), 32'd0);
      chk("R5 lock kept", 32'(lock_flags), 32'h3);

      // R6: repeats at locked phase, including back to back
      d0 = dets;
      pad_to(5); put_pat();
      run(1'b1, 3);
      chk("R6 repeat hit", 32'(dets - d0), 32'd1);
      d0 = dets;
      pad_to(5); put_pat(); put_pat();
      run(1'b1, 3);
      chk("R6 back to back hits", 32'(dets - d0), 32'd2);

      // R3: steady high level does not rearm
      run(1'b1, 10);
      d0 = dets;
      pad_to(12); put_pat();
      run(1'b1, 4);
      chk("R3 steady high no relock", 32'(dets - d0), 32'd0);

      // R7: new arming edge drops lock, then relock at phase 12
      run(1'b0, 2);
      run(1'b1, 1);
      noise(16);
      cycle(1'b0, 1'b1, take_word());
      chk("R7 edge clears lock", 32'(lock_flags), 32'h0);
      d0 = dets;
      pad_to(12); put_pat();
      run(1'b1, 4);
      chk("R7 relock", 32'(lock_flags), 32'h3);
      chk("R4 relock hit at new phase", 32'(dets - d0), 32'd1);

      // R1: enable high across reset arms on the first edge after release
      noise(16); cycle(1'b1, 1'b1, take_word());
      noise(16); cycle(1'b1, 1'b1, take_word());
      d0 = dets;
      pad_to(0); put_pat();
      run(1'b1, 4);
      chk("R1 armed after reset release", 32'(lock_flags), 32'h3);
      chk("R8 phase 0 hit", 32'(dets - d0), 32'd1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule